// File: doc/BRIEF.md
# Serial Peripheral Port (Master/Slave) with Slave-Select Gating

This block is a byte-wide synchronous serial port. It acts either as the clock-driving master or as a slave clocked from outside. One shift register sends and receives at once, with the most significant bit first. A completed byte goes into a receive holding register and raises a full flag. Software-facing strobes load the next byte, acknowledge the received one and clear the sticky error flags.

A 4-bit mode code selects the role. As master, the serial clock comes from one of two sources. The first is a per-cycle enable divided down by 4, 16 or 64. The second is an external timer pulse, with one pulse for each half period. As slave, the serial clock, data input and select input pass through two-flop synchronizers first. An optional select input can then hold the shift logic in reset. Two controls set the timing: one picks the clock edge on which output data changes, and the other moves the master's input sampling later by half a bit.

The block also contains a pin-direction wrapper for the data output pin. When the select input disables the port, the wrapper forces the direction readback to "input". Because of this, a read-modify-write of the direction bit made while the select is high leaves the data output turned off after the select drops again.

Top module: `spi_port`

## Requirements
- R1: After reset the receive register is 0x00, the full, collision and overflow flags are 0, `sck_o` is low, `dir_rd_o` reads 1 and `sdo_drive_o` is 0.
- R2: Mode codes: 4'b0000, 4'b0001 and 4'b0010 select master with an SCK period of 4, 16 or 64 `cyc_i` pulses. 4'b0011 selects master with an SCK period of two `tmr_i` pulses. 4'b0100 selects slave with select gating. 4'b0101 selects slave with the select ignored. Any other code disables the port, so `sdo_oe_o` and `sck_oe_o` are low.
- R3: A master write starts 8 SCK cycles, idle level low. The bits sent and received are MSB first. At the end the received byte appears on `rx_data_o` and `full_o` is set.
- R4: With `cke_i`=1, output data changes on the falling SCK edge and is sampled on the rising edge. The first bit is driven as soon as the byte is loaded. With `cke_i`=0, output data changes on the rising edge and is sampled on the falling edge.
- R5: In master mode, `smp_i`=1 samples the input half an SCK period after the edge used when `smp_i`=0. The received byte is still correct.
- R6: A write while a transfer is in progress sets `wcol_o` and does not change the byte being sent.
- R7: If a byte completes while `full_o` is still set, `ovfl_o` is set and `rx_data_o` keeps its old value.
- R8: `rd_ack_i` clears `full_o`. `flag_clr_i` clears `wcol_o` and `ovfl_o`.
- R9: In mode 4'b0100, a high `ssel_n_i` drops `sdo_oe_o` and resets the bit counter. A partly shifted byte is discarded, and the next byte needs a full 8 clocks.
- R10: In mode 4'b0100, while `ssel_n_i` is high, `dir_rd_o` reads 1. Writing that readback back into the direction bit leaves `sdo_drive_o` at 0 after the select falls.
- R11: In mode 4'b0101 with `cke_i`=1, `cfg_err_o` is high and no bits are received.
- R12: In slave mode the port shifts correctly on an external SCK that is asynchronous to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Role and clock-source code |
| cke_i | input | 1 | Output-change edge select |
| smp_i | input | 1 | Master late-sample select |
| cyc_i | input | 1 | Per-cycle enable feeding the divider |
| tmr_i | input | 1 | External timer pulse |
| wr_en_i | input | 1 | Load strobe for the next byte |
| wr_data_i | input | DATA_W | Byte to send |
| rd_ack_i | input | 1 | Acknowledge of the received byte |
| flag_clr_i | input | 1 | Clears collision and overflow |
| rx_data_o | output | DATA_W | Received byte |
| full_o | output | 1 | Received byte waiting |
| wcol_o | output | 1 | Write collision flag |
| ovfl_o | output | 1 | Receive overflow flag |
| cfg_err_o | output | 1 | Invalid slave edge setting |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock drive enable |
| sck_i | input | 1 | Serial clock in (slave) |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Peripheral output enable for data out |
| ssel_n_i | input | 1 | Slave select, active low |
| dir_wr_i | input | 1 | Direction-bit write strobe |
| dir_wdata_i | input | 1 | Direction-bit value, 1 = input |
| dir_rd_o | output | 1 | Direction-bit readback |
| sdo_drive_o | output | 1 | Final data-out pin drive enable |

## Verification
The bench uses the default `DATA_W`=8. Every master clock source can then be reached in a few hundred cycles: a period of 4, 16 and 64 with `cyc_i` high every cycle, and 6 cycles with a timer pulse every third cycle. A small bench-side peer device covers both edge settings and both sample phases in master mode. Slave transfers use a 12-cycle SCK, which is slow enough for the two-flop synchronizers and lets the select-reset and readback override be checked in the middle of a byte.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_i,
  input  logic              cke_i,
  input  logic              smp_i,
  input  logic              cyc_i,
  input  logic              tmr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_ack_i,
  input  logic              flag_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              wcol_o,
  output logic              ovfl_o,
  output logic              cfg_err_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              ssel_n_i,
  input  logic              dir_wr_i,
  input  logic              dir_wdata_i,
  output logic              dir_rd_o,
  output logic              sdo_drive_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int EDGES = 2 * DATA_W;
  localparam int TK_W  = $clog2(EDGES + 2);

  logic              is_master, is_slave, ss_en, periph_oe;
  logic [4:0]        half_m1, pre_q;
  logic              run_q, pend_q, sck_q, sdo_q, dir_q;
  logic [TK_W-1:0]   tk_q, tk_n, last_tk;
  logic              half_tick, m_edge, m_rise, m_fall, m_mid, m_shout, m_samp;
  logic [2:0]        sck_sy;
  logic [1:0]        sdi_sy, ss_sy;
  logic              s_act, s_rise, s_fall, s_samp, s_shout, ss_rst;
  logic              ev_samp, ev_shout, sin, busy, load, done;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sr_q, sr_next, rx_q;
  logic              full_q, wcol_q, ovfl_q;

  assign is_master = (mode_i[3:2] == 2'b00);
  assign is_slave  = (mode_i == 4'b0100) || (mode_i == 4'b0101);
  assign ss_en     = (mode_i == 4'b0100);
  assign cfg_err_o = (mode_i == 4'b0101) && cke_i;
  assign periph_oe = is_master || (is_slave && !(ss_en && ssel_n_i));

  always_comb begin
    case (mode_i[1:0])
      2'b00:   half_m1 = 5'd1;
      2'b01:   half_m1 = 5'd7;
      default: half_m1 = 5'd31;
    endcase
  end

  assign half_tick = run_q && ((mode_i == 4'b0011) ? tmr_i : (cyc_i && pre_q == half_m1));
  assign tk_n      = tk_q + 1'b1;
  assign last_tk   = (smp_i && !cke_i) ? TK_W'(EDGES + 1) : TK_W'(EDGES);
  assign m_edge    = half_tick && (tk_n <= TK_W'(EDGES));
  assign m_rise    = m_edge && tk_n[0];
  assign m_fall    = m_edge && !tk_n[0];
  assign m_mid     = cke_i ? m_rise : m_fall;
  assign m_shout   = cke_i ? m_fall : m_rise;
  assign m_samp    = smp_i ? (half_tick && pend_q) : m_mid;

  assign s_rise  = sck_sy[1] && !sck_sy[2];
  assign s_fall  = !sck_sy[1] && sck_sy[2];
  assign ss_rst  = ss_en && ss_sy[1];
  assign s_act   = is_slave && !ss_rst && !cfg_err_o;
  assign s_samp  = s_act && (cke_i ? s_rise : s_fall);
  assign s_shout = s_act && (cke_i ? s_fall : s_rise);

  assign ev_samp  = is_master ? m_samp  : s_samp;
  assign ev_shout = is_master ? m_shout : s_shout;
  assign sin      = is_master ? sdi_i : sdi_sy[1];
  assign busy     = is_master ? run_q : (cnt_q != '0);
  assign load     = wr_en_i && !busy && (is_master || is_slave);
  assign done     = ev_samp && (cnt_q == CNT_W'(DATA_W - 1));
  assign sr_next  = {sr_q[DATA_W-2:0], sin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      sdi_sy <= '0;
      ss_sy  <= 2'b11;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_i};
      sdi_sy <= {sdi_sy[0], sdi_i};
      ss_sy  <= {ss_sy[0], ssel_n_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      sck_q  <= 1'b0;
      tk_q   <= '0;
      pre_q  <= '0;
    end else if (load && is_master) begin
      run_q  <= 1'b1;
      pend_q <= 1'b0;
      sck_q  <= 1'b0;
      tk_q   <= '0;
      pre_q  <= '0;
    end else if (run_q) begin
      if (cyc_i) pre_q <= (pre_q == half_m1) ? 5'd0 : pre_q + 5'd1;
      if (half_tick) begin
        tk_q   <= tk_n;
        pend_q <= m_mid;
        if (m_edge) sck_q <= ~sck_q;
        if (tk_n == last_tk) run_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      sr_q  <= wr_data_i;
      sdo_q <= wr_data_i[DATA_W-1];
      cnt_q <= '0;
    end else begin
      if (ev_samp) begin
        sr_q  <= sr_next;
        cnt_q <= done ? '0 : cnt_q + 1'b1;
      end
      if (ev_shout) sdo_q <= ev_samp ? sr_q[DATA_W-2] : sr_q[DATA_W-1];
      if (ss_rst || cfg_err_o) cnt_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      full_q <= 1'b0;
      wcol_q <= 1'b0;
      ovfl_q <= 1'b0;
      dir_q  <= 1'b1;
    end else begin
      if (done && !full_q) begin
        rx_q   <= sr_next;
        full_q <= 1'b1;
      end else if (rd_ack_i) full_q <= 1'b0;
      if (done && full_q) ovfl_q <= 1'b1;
      else if (flag_clr_i) ovfl_q <= 1'b0;
      if (wr_en_i && busy) wcol_q <= 1'b1;
      else if (flag_clr_i) wcol_q <= 1'b0;
      if (dir_wr_i) dir_q <= dir_wdata_i;
    end
  end

  assign rx_data_o   = rx_q;
  assign full_o      = full_q;
  assign wcol_o      = wcol_q;
  assign ovfl_o      = ovfl_q;
  assign sck_o       = sck_q;
  assign sck_oe_o    = is_master;
  assign sdo_o       = sdo_q;
  assign sdo_oe_o    = periph_oe;
  assign dir_rd_o    = dir_q | ~periph_oe;
  assign sdo_drive_o = periph_oe & ~dir_q;

  a_r3_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !sck_o);
  a_r6_collision_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && busy) |=> wcol_o);
  a_r7_overflow_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovfl_o) |-> $stable(rx_data_o));
  a_r9_select_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    ss_rst |=> (cnt_q == '0));
  a_r10_readback_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_en && ssel_n_i) |-> (dir_rd_o && !sdo_drive_o));
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_i = 4'b0000;
  logic       cke_i = 1'b1, smp_i = 1'b0, cyc_i = 1'b1, tmr_i = 1'b0;
  logic       wr_en_i = 1'b0, rd_ack_i = 1'b0, flag_clr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rx_data_o;
  logic       full_o, wcol_o, ovfl_o, cfg_err_o, sck_o, sck_oe_o, sdo_o, sdo_oe_o;
  logic       sck_i = 1'b0, sdi_i = 1'b0, ssel_n_i = 1'b1;
  logic       dir_wr_i = 1'b0, dir_wdata_i = 1'b0, dir_rd_o, sdo_drive_o;
  int         n_run = 0, n_fail = 0;
  bit         finished = 0;

  always #4 clk = ~clk;

  spi_port #(.DATA_W(8)) i_spi_port (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cke_i(cke_i), .smp_i(smp_i),
    .cyc_i(cyc_i), .tmr_i(tmr_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_ack_i(rd_ack_i), .flag_clr_i(flag_clr_i), .rx_data_o(rx_data_o),
    .full_o(full_o), .wcol_o(wcol_o), .ovfl_o(ovfl_o), .cfg_err_o(cfg_err_o),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o), .sck_i(sck_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .ssel_n_i(ssel_n_i),
    .dir_wr_i(dir_wr_i), .dir_wdata_i(dir_wdata_i), .dir_rd_o(dir_rd_o),
    .sdo_drive_o(sdo_drive_o));

  // {mode, cke, smp, byte sent, peer byte, SCK period in clk cycles}
  localparam logic [29:0] VEC [0:5] = '{
    {4'h0, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'd4},
    {4'h0, 1'b0, 1'b0, 8'h5A, 8'hC3, 8'd4},
    {4'h1, 1'b1, 1'b1, 8'hF0, 8'h0F, 8'd16},
    {4'h2, 1'b0, 1'b1, 8'h81, 8'h7E, 8'd64},
    {4'h3, 1'b1, 1'b0, 8'h96, 8'h69, 8'd6},
    {4'h0, 1'b0, 1'b1, 8'h01, 8'h80, 8'd4}
  };

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      tmr_i = 1'b1;
      @(negedge clk);
      tmr_i = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_ack();
    @(negedge clk); rd_ack_i = 1'b1;
    @(negedge clk); rd_ack_i = 1'b0;
  endtask

  task automatic run_master(input logic [7:0] tx, input logic [7:0] peer, input bit midwrite,
                            output logic [7:0] seen, output int period);
    int idx, edges, cyc, t1;
    logic prev;
    seen = '0; period = 0; t1 = -1; edges = 0; cyc = 0; prev = 1'b0;
    idx = cke_i ? 6 : 7;
    sdi_i = cke_i ? peer[7] : 1'b0;
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = tx;
    @(negedge clk); wr_en_i = 1'b0;
    while (edges < 16 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (midwrite && cyc == 5) begin wr_en_i = 1'b1; wr_data_i = ~tx; end
      else wr_en_i = 1'b0;
      if (sck_o !== prev) begin
        edges++;
        prev = sck_o;
        if (sck_o) begin
          if (t1 < 0) t1 = cyc;
          else if (period == 0) period = cyc - t1;
        end
        if (cke_i ? !sck_o : sck_o) begin
          if (idx >= 0) sdi_i = peer[idx];
          idx--;
        end else seen = {seen[6:0], sdo_o};
      end
    end
    wr_en_i = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic slave_xfer(input int nbits, input logic [7:0] peer, output logic [7:0] seen);
    seen = '0;
    if (cke_i) begin
      sdi_i = peer[7];
      for (int i = 0; i < nbits; i++) begin
        repeat (6) @(negedge clk);
        seen = {seen[6:0], sdo_o};
        sck_i = 1'b1;
        repeat (6) @(negedge clk);
        sck_i = 1'b0;
        if (i < 7) sdi_i = peer[6-i];
      end
    end else begin
      for (int i = 0; i < nbits; i++) begin
        sck_i = 1'b1;
        sdi_i = peer[7-i];
        repeat (6) @(negedge clk);
        seen = {seen[6:0], sdo_o};
        sck_i = 1'b0;
        repeat (6) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen;
    int per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rx", rx_data_o, 8'h00);
    chk("R1 flags", {full_o, wcol_o, ovfl_o}, 3'b000);
    chk("R1 sck", sck_o, 1'b0);
    chk("R1 dir readback", dir_rd_o, 1'b1);
    chk("R1 pin drive", sdo_drive_o, 1'b0);

    for (int v = 0; v < 6; v++) begin
      mode_i = VEC[v][29:26]; cke_i = VEC[v][25]; smp_i = VEC[v][24];
      run_master(VEC[v][23:16], VEC[v][15:8], 1'b0, seen, per);
      chk("R2 sck period", per, VEC[v][7:0]);
      chk("R4 R5 bits out", seen, VEC[v][23:16]);
      chk("R3 R5 byte in", rx_data_o, VEC[v][15:8]);
      chk("R3 full", full_o, 1'b1);
      pulse_ack();
      chk("R8 ack clears full", full_o, 1'b0);
    end

    mode_i = 4'h0; cke_i = 1'b1; smp_i = 1'b0;
    run_master(8'h11, 8'h22, 1'b1, seen, per);
    chk("R6 collision flag", wcol_o, 1'b1);
    chk("R6 byte unchanged", seen, 8'h11);
    chk("R3 byte in", rx_data_o, 8'h22);
    run_master(8'h33, 8'h44, 1'b0, seen, per);
    chk("R7 overflow flag", ovfl_o, 1'b1);
    chk("R7 old byte kept", rx_data_o, 8'h22);
    @(negedge clk); flag_clr_i = 1'b1;
    @(negedge clk); flag_clr_i = 1'b0;
    chk("R8 flags cleared", {wcol_o, ovfl_o}, 2'b00);
    chk("R8 full untouched", full_o, 1'b1);
    pulse_ack();

    mode_i = 4'b0101; cke_i = 1'b0;
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'hC6;
    @(negedge clk); wr_en_i = 1'b0;
    slave_xfer(8, 8'h5B, seen);
    chk("R12 R4 slave bits out", seen, 8'hC6);
    chk("R12 slave byte in", rx_data_o, 8'h5B);
    chk("R12 slave full", full_o, 1'b1);
    pulse_ack();

    mode_i = 4'b0100; cke_i = 1'b1; ssel_n_i = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h9D;
    @(negedge clk); wr_en_i = 1'b0;
    slave_xfer(3, 8'hE0, seen);
    ssel_n_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 oe dropped", sdo_oe_o, 1'b0);
    chk("R10 readback forced", dir_rd_o, 1'b1);
    chk("R9 no byte", full_o, 1'b0);
    ssel_n_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 oe back", sdo_oe_o, 1'b1);
    slave_xfer(8, 8'h4B, seen);
    chk("R9 fresh byte", rx_data_o, 8'h4B);
    chk("R9 full", full_o, 1'b1);
    pulse_ack();

    @(negedge clk); dir_wr_i = 1'b1; dir_wdata_i = 1'b0;
    @(negedge clk); dir_wr_i = 1'b0;
    chk("R10 pin driven", sdo_drive_o, 1'b1);
    ssel_n_i = 1'b1;
    @(negedge clk);
    chk("R10 readback high", dir_rd_o, 1'b1);
    dir_wdata_i = dir_rd_o; dir_wr_i = 1'b1;
    @(negedge clk); dir_wr_i = 1'b0;
    ssel_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 pin left off", sdo_drive_o, 1'b0);
    chk("R10 readback stored", dir_rd_o, 1'b1);

    mode_i = 4'b0101; cke_i = 1'b1;
    @(negedge clk);
    chk("R11 config error", cfg_err_o, 1'b1);
    slave_xfer(8, 8'hA3, seen);
    chk("R11 nothing received", full_o, 1'b0);
    cke_i = 1'b0;
    @(negedge clk);
    chk("R11 error clears", cfg_err_o, 1'b0);

    mode_i = 4'b0111;
    @(negedge clk);
    chk("R2 off code", {sdo_oe_o, sck_oe_o}, 2'b00);
    mode_i = 4'b0000;
    @(negedge clk);
    chk("R2 master drives sck", sck_oe_o, 1'b1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule